// File: doc/BRIEF.md
# Clock Monitor Reset Controller

This block sits between a loss-of-clock detector and the reset sequence generator. It chooses how the clock system reacts when the oscillator disappears. Two control bits decide the reaction: a monitor enable and a fallback enable. With the monitor off, a lost clock is ignored. With the monitor on and fallback enabled, the block moves the clock system onto its self-clocked fallback and raises no reset. With the monitor on and fallback disabled, the block requests a reset.

A monitor reset also loads both control bits with their default value of 1. Because fallback is then enabled, the block is in self-clock mode from the same cycle as the reset request. The clock quality check runs alongside the reset sequence. When it reports a good oscillator, the block selects the oscillator again and leaves self-clock mode, even if the downstream reset sequence is still running.

Both status inputs come from other timing domains. Each passes through a synchronizer that is `SYNC_STAGES` flops deep. The control bits are loaded through a one-cycle write strobe and can be read back at all times.

Top module: `clkmon_rst_ctl`

## Requirements
- R1: `rst_req` is 1 in a cycle only if, in the previous cycle, `mon_en` was 1, `selfclk_en` was 0 and the synchronized loss indication was 1.
- R2: In the cycle that `rst_req` is 1, both `mon_en` and `selfclk_en` read 1.
- R3: In the cycle that `rst_req` is 1, `selfclk_mode` is 1 and `osc_sel` is 0.
- R4: A synchronized loss indication with `mon_en` = 1 and `selfclk_en` = 1 sets `selfclk_mode` on the next edge and raises no reset request.
- R5: With no synchronized loss entering fallback, a synchronized good-clock indication clears `selfclk_mode` and sets `osc_sel` on the next edge. A loss that enters fallback in the same cycle wins over the good-clock indication.
- R6: While `mon_en` is 0, loss indications have no effect: there is no reset request, no entry into fallback and no change of the control bits.
- R7: `rst_req` is a registered pulse that is never high for two consecutive cycles.
- R8: `osc_sel` is always the complement of `selfclk_mode`. A value of 1 on `osc_sel` selects the oscillator.
- R9: While `rst_n` is low, the outputs are `mon_en` = 1, `selfclk_en` = 1, `selfclk_mode` = 0, `osc_sel` = 1 and `rst_req` = 0.
- R10: When `cfg_wr` is high, `cfg_mon_en` and `cfg_selfclk_en` are loaded into `mon_en` and `selfclk_en` on that edge. A monitor reset decided in the same cycle overrides the write.
- R11: A change on `loss_det` or `clk_good` first acts on the outputs `SYNC_STAGES`+1 edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| loss_det | input | 1 | Loss-of-oscillator indication, asynchronous |
| clk_good | input | 1 | Clock-quality-valid indication, asynchronous |
| cfg_wr | input | 1 | Write strobe for the control bits |
| cfg_mon_en | input | 1 | Write data for the monitor enable |
| cfg_selfclk_en | input | 1 | Write data for the fallback enable |
| mon_en | output | 1 | Current monitor enable |
| selfclk_en | output | 1 | Current fallback enable |
| rst_req | output | 1 | One-cycle reset request to the reset sequence generator |
| selfclk_mode | output | 1 | Clock system is running on the self-clocked fallback |
| osc_sel | output | 1 | 1 selects the oscillator clock |

## Verification
The bench builds the block with `SYNC_STAGES` = 2. At that depth, every input pattern reaches the outputs within three edges, so a sweep over all ordered pairs of the five input bits (1024 pairs) fits in a few thousand cycles. The sweep drives the block through every combination of control bits, loss, good-clock and write activity, including writes that collide with a monitor reset. It also covers loss and good-clock arriving together. Directed sequences then pin down the exact latency of a reset request and of the fallback exit.

// File: rtl/clkmon_rst_ctl.sv
module clkmon_rst_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loss_det,
  input  logic clk_good,
  input  logic cfg_wr,
  input  logic cfg_mon_en,
  input  logic cfg_selfclk_en,
  output logic mon_en,
  output logic selfclk_en,
  output logic rst_req,
  output logic selfclk_mode,
  output logic osc_sel
);

  logic [SYNC_STAGES-1:0] loss_q, good_q;
  logic loss_s, good_s, fire, fallback;

  assign loss_s   = loss_q[SYNC_STAGES-1];
  assign good_s   = good_q[SYNC_STAGES-1];
  assign fire     = mon_en & loss_s & ~selfclk_en;
  assign fallback = mon_en & loss_s & selfclk_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loss_q <= '0;
      good_q <= '0;
    end else begin
      loss_q <= SYNC_STAGES'({loss_q, loss_det});
      good_q <= SYNC_STAGES'({good_q, clk_good});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mon_en     <= 1'b1;
      selfclk_en <= 1'b1;
    end else if (fire) begin
      mon_en     <= 1'b1;
      selfclk_en <= 1'b1;
    end else if (cfg_wr) begin
      mon_en     <= cfg_mon_en;
      selfclk_en <= cfg_selfclk_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req      <= 1'b0;
      selfclk_mode <= 1'b0;
      osc_sel      <= 1'b1;
    end else begin
      rst_req <= fire;
      if (fire || fallback) begin
        selfclk_mode <= 1'b1;
        osc_sel      <= 1'b0;
      end else if (good_s) begin
        selfclk_mode <= 1'b0;
        osc_sel      <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/clkmon_rst_ctl_chk.sv
module clkmon_rst_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic selfclk_en,
  input logic rst_req,
  input logic selfclk_mode,
  input logic osc_sel
);

  // R1
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(mon_en && !selfclk_en));

  // R2
  bits_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (mon_en && selfclk_en));

  // R3
  req_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (selfclk_mode && !osc_sel));

  // R4
  fallback_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mon_en && selfclk_en) |-> !rst_req);

  // R6
  mon_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!mon_en) |-> !rst_req);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R8
  sel_mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    osc_sel != selfclk_mode);

endmodule

bind clkmon_rst_ctl clkmon_rst_ctl_chk u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .mon_en(mon_en),
  .selfclk_en(selfclk_en),
  .rst_req(rst_req),
  .selfclk_mode(selfclk_mode),
  .osc_sel(osc_sel)
);

// File: tb/clkmon_rst_ctl_test.sv
`timescale 1ns/1ps
module clkmon_rst_ctl_test;
  localparam int N = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic loss_det = 1'b0, clk_good = 1'b0, cfg_wr = 1'b0;
  logic cfg_mon_en = 1'b0, cfg_selfclk_en = 1'b0;
  logic mon_en, selfclk_en, rst_req, selfclk_mode, osc_sel;

  clkmon_rst_ctl #(.SYNC_STAGES(N)) uut (
    .clk(clk), .rst_n(rst_n), .loss_det(loss_det), .clk_good(clk_good),
    .cfg_wr(cfg_wr), .cfg_mon_en(cfg_mon_en), .cfg_selfclk_en(cfg_selfclk_en),
    .mon_en(mon_en), .selfclk_en(selfclk_en), .rst_req(rst_req),
    .selfclk_mode(selfclk_mode), .osc_sel(osc_sel)
  );

  int vecs = 0, errs = 0;
  logic m_mon = 1'b1, m_sc = 1'b1, m_scm = 1'b0, m_rst = 1'b0;
  logic [N-1:0] m_ls = '0, m_ok = '0;

  task automatic chk(input string tag, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic l, input logic o, input logic w,
                      input logic wm, input logic ws);
    logic fire, ent;
    loss_det = l; clk_good = o; cfg_wr = w; cfg_mon_en = wm; cfg_selfclk_en = ws;
    @(negedge clk);
    fire = m_mon & m_ls[N-1] & ~m_sc;
    ent  = m_mon & m_ls[N-1] & m_sc;
    m_rst = fire;
    if (fire) begin
      m_mon = 1'b1; m_sc = 1'b1; m_scm = 1'b1;
    end else begin
      if (w) begin m_mon = wm; m_sc = ws; end
      if (ent) m_scm = 1'b1;
      else if (m_ok[N-1]) m_scm = 1'b0;
    end
    m_ls = N'({m_ls, l});
    m_ok = N'({m_ok, o});
    chk("R1 rst_req", rst_req, m_rst);
    chk("R4 selfclk_mode", selfclk_mode, m_scm);
    chk("R8 osc_sel", osc_sel, ~m_scm);
    chk("R10 mon_en", mon_en, m_mon);
    chk("R10 selfclk_en", selfclk_en, m_sc);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 mon_en", mon_en, 1'b1);
    chk("R9 selfclk_en", selfclk_en, 1'b1);
    chk("R9 selfclk_mode", selfclk_mode, 1'b0);
    chk("R9 osc_sel", osc_sel, 1'b1);
    chk("R9 rst_req", rst_req, 1'b0);
    rst_n = 1'b1;

    // R6: monitor off, loss held
    step(0, 0, 1, 0, 0);
    for (int i = 0; i < 6; i++) begin
      step(1, 0, 0, 0, 0);
      chk("R6 rst_req", rst_req, 1'b0);
      chk("R6 selfclk_mode", selfclk_mode, 1'b0);
      chk("R6 mon_en", mon_en, 1'b0);
    end
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // R1 R2 R3 R11 R7: monitor reset latency
    step(0, 0, 1, 1, 0);
    step(0, 0, 0, 0, 0);
    for (int i = 1; i <= N + 1; i++) begin
      step(1, 0, 0, 0, 0);
      chk("R11 rst_req latency", rst_req, logic'(i == N + 1));
    end
    chk("R2 mon_en", mon_en, 1'b1);
    chk("R2 selfclk_en", selfclk_en, 1'b1);
    chk("R3 selfclk_mode", selfclk_mode, 1'b1);
    chk("R3 osc_sel", osc_sel, 1'b0);
    step(0, 0, 0, 0, 0);
    chk("R7 rst_req low", rst_req, 1'b0);
    for (int i = 0; i < N + 1; i++) step(0, 0, 0, 0, 0);

    // R5 fallback exit latency
    for (int i = 1; i <= N + 1; i++) begin
      step(0, 1, 0, 0, 0);
      chk("R5 selfclk_mode", selfclk_mode, logic'(i != N + 1));
    end
    chk("R5 osc_sel", osc_sel, 1'b1);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);

    // R4 fallback without reset
    for (int i = 1; i <= N + 1; i++) step(1, 0, 0, 0, 0);
    chk("R4 selfclk_mode", selfclk_mode, 1'b1);
    chk("R4 rst_req", rst_req, 1'b0);

    // Sweep over all ordered pairs of input vectors
    for (int pass = 0; pass < 3; pass++) begin
      for (int p = 0; p < 1024; p++) begin
        step(p[0], p[1], p[2], p[3], p[4]);
        step(p[5], p[6], p[7], p[8], p[9]);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule